// File: doc/BRIEF.md
# Interlaken Metaframe Synchronizer

This block finds and then follows the metaframe boundaries of one received Interlaken lane. Its input is a stream of 64-bit words that have already been block-aligned. Each word carries a control/data flag. A qualifier reports whether the upstream bit-level aligner currently has block lock. The block looks for the synchronization control word and confirms it at the configured metaframe period before it declares frame lock. After that, it checks the fixed control-word slots of every metaframe.

Once it is locked, the block reports several events. It marks each metaframe start with a pulse. It flags a missing synchronization word at a boundary. It reports skip words found outside the skip slot, and the skip slot holding anything other than a skip word. It keeps status flags for synchronization-word, skip-word and diagnostic-word errors. These status flags are frozen while block lock is absent. Descrambling, CRC checking and bit-level alignment belong to neighbouring blocks.

Top module: `mframe_sync`

## Requirements
- R1: Frame lock (`frame_lock`) rises in the cycle after the fourth synchronization word is seen at consecutive expected positions, spaced one metaframe apart. A synchronization word is the exact value 64'h78F678F678F678F6 with `word_ctrl`=1. Frame lock stays low after only three such words.
- R2: While confirming, a word at the expected boundary that is not a synchronization word abandons the attempt. Counting then restarts from the next synchronization word, which again needs four in total.
- R3: While locked, position 1 of every metaframe must hold a scrambler-state word (`word_ctrl`=1, bits 63:58 = 6'b001010). Three consecutive failures drop frame lock in the following cycle. A good word between failures clears the failure count.
- R4: While locked, `mf_start` pulses for one cycle after each word at position 0. This includes the word that completes lock.
- R5: While locked, a position-0 word that is not a synchronization word pulses `mfrm_err` together with `mf_start`, and frame lock is kept. The status flag `sync_err` takes the value "position-0 word was not a synchronization word" at every locked boundary.
- R6: While locked, position 2 is the skip slot, and a skip word is exactly 64'h1E00000000000000 with `word_ctrl`=1. If the slot holds any other word, `pyld_ins` pulses. If it holds a control word with bits 63:58 = 6'b000111 that is not the exact skip word, status `skip_err` is set; otherwise `skip_err` is cleared.
- R7: While locked, a skip word at any position other than 2 pulses `skip_ins`.
- R8: While locked, the last position of the metaframe (length minus one) must hold a diagnostic word (`word_ctrl`=1, bits 63:58 = 6'b011001). Status `diag_err` is set when it does not and cleared when it does.
- R9: When `blk_lock` is low, `frame_lock` is low on the next clock and the search restarts. Words are ignored, and `sync_err`, `skip_err` and `diag_err` keep their values.
- R10: `cfg_len` is captured once, as the block leaves reset. A value below 4 is treated as 4. Later changes of `cfg_len` have no effect.
- R11: Cycles with `word_valid` low do not advance the metaframe position and are not checked.
- R12: During and right after reset, all outputs are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Lane word clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| cfg_len | input | LEN_W | Metaframe length in words, captured when leaving reset |
| blk_lock | input | 1 | Block lock from the bit-level aligner |
| word_valid | input | 1 | Word present this cycle |
| word_ctrl | input | 1 | 1 = control word, 0 = data word |
| word_data | input | 64 | Received word |
| frame_lock | output | 1 | Metaframe lock achieved |
| mf_start | output | 1 | Pulse: metaframe start while locked |
| mfrm_err | output | 1 | Pulse: synchronization word missing at a locked boundary |
| sync_err | output | 1 | Status: last locked boundary lacked the synchronization word |
| skip_ins | output | 1 | Pulse: skip word outside the skip slot |
| pyld_ins | output | 1 | Pulse: skip slot held a non-skip word |
| skip_err | output | 1 | Status: skip slot held a corrupted skip word |
| diag_err | output | 1 | Status: diagnostic slot held a wrong word |

## Verification
The hardest situation to reach from the ports is the loss of block lock while all three status flags are set. The block must not clear them, even when a stream of well-formed metaframes arrives during the loss. To get there, the stimulus first acquires lock. It then sends one metaframe whose boundary, skip slot and diagnostic slot are all corrupted. Next it lowers `blk_lock` and sends good metaframes while it observes the flags. It then restores block lock and reacquires frame lock. The non-consecutive scrambler failure pattern (two bad, one good, two bad, then a third bad) is driven the same way, after lock.

// File: rtl/mframe_sync_pkg.sv
package mframe_sync_pkg;

    localparam int TYPE_HI = 63;
    localparam int TYPE_LO = 58;

    localparam logic [63:0] SYNC_PATTERN = 64'h78F6_78F6_78F6_78F6;
    localparam logic [63:0] SKIP_PATTERN = 64'h1E00_0000_0000_0000;
    localparam logic [5:0]  TYPE_SCRAM   = 6'b001010;
    localparam logic [5:0]  TYPE_SKIP    = 6'b000111;
    localparam logic [5:0]  TYPE_DIAG    = 6'b011001;

    typedef enum logic [1:0] {
        ST_RESET  = 2'd0,
        ST_SEARCH = 2'd1,
        ST_VERIFY = 2'd2,
        ST_LOCKED = 2'd3
    } msync_state_e;

    typedef struct packed {
        logic is_sync;
        logic is_scram;
        logic is_skip;
        logic is_bad_skip;
        logic is_diag;
    } word_kind_t;

endpackage

// File: rtl/mframe_word_class.sv
module mframe_word_class
    import mframe_sync_pkg::*;
(
    input  logic        word_ctrl,
    input  logic [63:0] word_data,
    output word_kind_t  kind
);

    logic [5:0] tcode;
    assign tcode = word_data[TYPE_HI:TYPE_LO];

    always_comb begin
        kind.is_sync     = word_ctrl && (word_data == SYNC_PATTERN);
        kind.is_scram    = word_ctrl && (tcode == TYPE_SCRAM);
        kind.is_skip     = word_ctrl && (word_data == SKIP_PATTERN);
        kind.is_bad_skip = word_ctrl && (tcode == TYPE_SKIP) && (word_data != SKIP_PATTERN);
        kind.is_diag     = word_ctrl && (tcode == TYPE_DIAG);
    end

endmodule

// File: rtl/mframe_slot_ctr.sv
module mframe_slot_ctr #(
    parameter int LEN_W   = 14,
    parameter int MIN_LEN = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load_len,
    input  logic [LEN_W-1:0] cfg_len,
    input  logic             advance,
    input  logic             restart,
    output logic             at_sync,
    output logic             at_scram,
    output logic             at_skip,
    output logic             at_diag
);

    localparam logic [LEN_W-1:0] LEN_FLOOR = LEN_W'(MIN_LEN);

    typedef struct packed {
        logic [LEN_W-1:0] len;
        logic [LEN_W-1:0] pos;
    } slot_regs_t;

    slot_regs_t q, d;

    always_comb begin
        d = q;
        if (load_len) begin
            d.len = (cfg_len < LEN_FLOOR) ? LEN_FLOOR : cfg_len;
            d.pos = '0;
        end else if (restart) begin
            d.pos = LEN_W'(1);
        end else if (advance) begin
            d.pos = (q.pos == q.len - 1'b1) ? '0 : q.pos + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q.len <= LEN_FLOOR;
            q.pos <= '0;
        end else begin
            q <= d;
        end
    end

    assign at_sync  = (q.pos == '0);
    assign at_scram = (q.pos == LEN_W'(1));
    assign at_skip  = (q.pos == LEN_W'(2));
    assign at_diag  = (q.pos == q.len - 1'b1);

endmodule

// File: rtl/mframe_sync_fsm.sv
module mframe_sync_fsm
    import mframe_sync_pkg::*;
#(
    parameter int LOCK_SYNCS      = 4,
    parameter int LOSS_MISMATCHES = 3
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       blk_lock,
    input  logic       word_valid,
    input  word_kind_t kind,
    input  logic       at_sync,
    input  logic       at_scram,
    input  logic       at_skip,
    input  logic       at_diag,
    output logic       load_len,
    output logic       advance,
    output logic       restart,
    output logic       frame_lock,
    output logic       mf_start,
    output logic       mfrm_err,
    output logic       sync_err,
    output logic       skip_ins,
    output logic       pyld_ins,
    output logic       skip_err,
    output logic       diag_err
);

    localparam int SC_W = $clog2(LOCK_SYNCS + 1);
    localparam int MC_W = $clog2(LOSS_MISMATCHES + 1);
    localparam logic [SC_W-1:0] SYNC_LAST = SC_W'(LOCK_SYNCS - 1);
    localparam logic [MC_W-1:0] MISS_LAST = MC_W'(LOSS_MISMATCHES - 1);

    typedef struct packed {
        msync_state_e    state;
        logic [SC_W-1:0] sync_cnt;
        logic [MC_W-1:0] miss_cnt;
        logic            mf_start;
        logic            mfrm_err;
        logic            skip_ins;
        logic            pyld_ins;
        logic            sync_err;
        logic            skip_err;
        logic            diag_err;
    } fsm_regs_t;

    fsm_regs_t q, d;
    logic      take;

    assign take     = blk_lock && word_valid;
    assign load_len = (q.state == ST_RESET);
    assign advance  = take;
    assign restart  = (q.state == ST_SEARCH) && take && kind.is_sync;

    always_comb begin
        d          = q;
        d.mf_start = 1'b0;
        d.mfrm_err = 1'b0;
        d.skip_ins = 1'b0;
        d.pyld_ins = 1'b0;
        unique case (q.state)
            ST_RESET: d.state = ST_SEARCH;
            ST_SEARCH: begin
                if (restart) begin
                    d.state    = ST_VERIFY;
                    d.sync_cnt = SC_W'(1);
                end
            end
            ST_VERIFY: begin
                if (take && at_sync) begin
                    if (!kind.is_sync) begin
                        d.state    = ST_SEARCH;
                        d.sync_cnt = '0;
                    end else if (q.sync_cnt == SYNC_LAST) begin
                        d.state    = ST_LOCKED;
                        d.sync_cnt = '0;
                        d.miss_cnt = '0;
                        d.mf_start = 1'b1;
                    end else begin
                        d.sync_cnt = q.sync_cnt + 1'b1;
                    end
                end
            end
            ST_LOCKED: begin
                if (take) begin
                    if (at_sync) begin
                        d.mf_start = 1'b1;
                        d.mfrm_err = !kind.is_sync;
                        d.sync_err = !kind.is_sync;
                    end
                    if (at_scram) begin
                        if (kind.is_scram) begin
                            d.miss_cnt = '0;
                        end else if (q.miss_cnt == MISS_LAST) begin
                            d.state    = ST_SEARCH;
                            d.miss_cnt = '0;
                        end else begin
                            d.miss_cnt = q.miss_cnt + 1'b1;
                        end
                    end
                    if (at_skip) begin
                        d.pyld_ins = !kind.is_skip;
                        d.skip_err = kind.is_bad_skip;
                    end else if (kind.is_skip) begin
                        d.skip_ins = 1'b1;
                    end
                    if (at_diag) begin
                        d.diag_err = !kind.is_diag;
                    end
                end
            end
            default: d.state = ST_SEARCH;
        endcase
        if (!blk_lock && q.state != ST_RESET) begin
            d.state    = ST_SEARCH;
            d.sync_cnt = '0;
            d.miss_cnt = '0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q <= '{state: ST_RESET, default: '0};
        end else begin
            q <= d;
        end
    end

    assign frame_lock = (q.state == ST_LOCKED);
    assign mf_start   = q.mf_start;
    assign mfrm_err   = q.mfrm_err;
    assign sync_err   = q.sync_err;
    assign skip_ins   = q.skip_ins;
    assign pyld_ins   = q.pyld_ins;
    assign skip_err   = q.skip_err;
    assign diag_err   = q.diag_err;

endmodule

// File: rtl/mframe_sync.sv
module mframe_sync
    import mframe_sync_pkg::*;
#(
    parameter int LEN_W           = 14,
    parameter int MIN_LEN         = 4,
    parameter int LOCK_SYNCS      = 4,
    parameter int LOSS_MISMATCHES = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [LEN_W-1:0] cfg_len,
    input  logic             blk_lock,
    input  logic             word_valid,
    input  logic             word_ctrl,
    input  logic [63:0]      word_data,
    output logic             frame_lock,
    output logic             mf_start,
    output logic             mfrm_err,
    output logic             sync_err,
    output logic             skip_ins,
    output logic             pyld_ins,
    output logic             skip_err,
    output logic             diag_err
);

    word_kind_t kind;
    logic       load_len, advance, restart;
    logic       at_sync, at_scram, at_skip, at_diag;

    mframe_word_class u_class (
        .word_ctrl (word_ctrl),
        .word_data (word_data),
        .kind      (kind)
    );

    mframe_slot_ctr #(
        .LEN_W   (LEN_W),
        .MIN_LEN (MIN_LEN)
    ) u_slots (
        .clk      (clk),
        .rst_n    (rst_n),
        .load_len (load_len),
        .cfg_len  (cfg_len),
        .advance  (advance),
        .restart  (restart),
        .at_sync  (at_sync),
        .at_scram (at_scram),
        .at_skip  (at_skip),
        .at_diag  (at_diag)
    );

    mframe_sync_fsm #(
        .LOCK_SYNCS      (LOCK_SYNCS),
        .LOSS_MISMATCHES (LOSS_MISMATCHES)
    ) u_fsm (
        .clk        (clk),
        .rst_n      (rst_n),
        .blk_lock   (blk_lock),
        .word_valid (word_valid),
        .kind       (kind),
        .at_sync    (at_sync),
        .at_scram   (at_scram),
        .at_skip    (at_skip),
        .at_diag    (at_diag),
        .load_len   (load_len),
        .advance    (advance),
        .restart    (restart),
        .frame_lock (frame_lock),
        .mf_start   (mf_start),
        .mfrm_err   (mfrm_err),
        .sync_err   (sync_err),
        .skip_ins   (skip_ins),
        .pyld_ins   (pyld_ins),
        .skip_err   (skip_err),
        .diag_err   (diag_err)
    );

endmodule

// File: rtl/mframe_sync_chk.sv
module mframe_sync_chk
    import mframe_sync_pkg::*;
(
    input logic        clk,
    input logic        rst_n,
    input logic        blk_lock,
    input logic        word_valid,
    input logic        word_ctrl,
    input logic [63:0] word_data,
    input logic        frame_lock,
    input logic        mf_start,
    input logic        mfrm_err,
    input logic        sync_err,
    input logic        skip_ins,
    input logic        pyld_ins,
    input logic        skip_err,
    input logic        diag_err
);

    assert_lock_on_sync_R1: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(frame_lock) |->
            $past(blk_lock && word_valid && word_ctrl && word_data == SYNC_PATTERN));

    assert_loss_cause_R3: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(frame_lock) |->
            (!$past(blk_lock) ||
             $past(word_valid && !(word_ctrl && word_data[TYPE_HI:TYPE_LO] == TYPE_SCRAM))));

    assert_start_when_locked_R4: assert property (@(posedge clk) disable iff (!rst_n)
        mf_start |-> frame_lock);

    assert_mfrm_at_boundary_R5: assert property (@(posedge clk) disable iff (!rst_n)
        mfrm_err |-> (mf_start && sync_err));

    assert_slot_pulses_excl_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !(skip_ins && pyld_ins));

    assert_drop_on_blk_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !blk_lock |=> !frame_lock);

    assert_frozen_flags_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !blk_lock |=> ($stable(sync_err) && $stable(skip_err) && $stable(diag_err)));

endmodule

bind mframe_sync mframe_sync_chk u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .blk_lock   (blk_lock),
    .word_valid (word_valid),
    .word_ctrl  (word_ctrl),
    .word_data  (word_data),
    .frame_lock (frame_lock),
    .mf_start   (mf_start),
    .mfrm_err   (mfrm_err),
    .sync_err   (sync_err),
    .skip_ins   (skip_ins),
    .pyld_ins   (pyld_ins),
    .skip_err   (skip_err),
    .diag_err   (diag_err)
);

// File: tb/mframe_sync_bench.sv
module mframe_sync_bench;

    localparam int LEN_W = 14;
    localparam logic [63:0] W_SYNC  = 64'h78F6_78F6_78F6_78F6;
    localparam logic [63:0] W_SCRAM = 64'h2800_0000_0000_1234;
    localparam logic [63:0] W_SKIP  = 64'h1E00_0000_0000_0000;
    localparam logic [63:0] W_BSKIP = 64'h1E00_0000_0000_0001;
    localparam logic [63:0] W_DIAG  = 64'h6400_0000_0000_0000;
    localparam logic [63:0] W_DATA  = 64'hC3C3_5A5A_0000_0000;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic [LEN_W-1:0] cfg_len = LEN_W'(8);
    logic             blk_lock = 1'b1;
    logic             word_valid = 1'b0;
    logic             word_ctrl = 1'b0;
    logic [63:0]      word_data = '0;
    logic frame_lock, mf_start, mfrm_err, sync_err, skip_ins, pyld_ins, skip_err, diag_err;

    int n_checks = 0;
    int n_fail   = 0;

    logic cap_lock0, cap_start0, cap_mfrm0, cap_serr0, cap_lock1;
    logic cap_pyld2, cap_skerr2, cap_skins, cap_derr, cap_lock_end;

    always #5 clk = ~clk;

    mframe_sync #(.LEN_W(LEN_W)) u_mframe_sync (
        .clk(clk), .rst_n(rst_n), .cfg_len(cfg_len), .blk_lock(blk_lock),
        .word_valid(word_valid), .word_ctrl(word_ctrl), .word_data(word_data),
        .frame_lock(frame_lock), .mf_start(mf_start), .mfrm_err(mfrm_err),
        .sync_err(sync_err), .skip_ins(skip_ins), .pyld_ins(pyld_ins),
        .skip_err(skip_err), .diag_err(diag_err)
    );

    task automatic check(input string req, input string what, input logic got, input logic exp);
        n_checks++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %0b expected %0b", req, what, got, exp);
        end
    endtask

    task automatic drive(input logic c, input logic [63:0] d);
        @(negedge clk);
        word_valid = 1'b1;
        word_ctrl  = c;
        word_data  = d;
        @(posedge clk);
        #1;
        word_valid = 1'b0;
    endtask

    task automatic idle();
        @(negedge clk);
        word_valid = 1'b0;
        @(posedge clk);
        #1;
    endtask

    task automatic apply_reset(input int len);
        rst_n      = 1'b0;
        blk_lock   = 1'b1;
        word_valid = 1'b0;
        cfg_len    = LEN_W'(len);
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        repeat (2) @(posedge clk);
        #1;
    endtask

    // sync_k/scram_k/diag_k: 0 good, 1 data word; skip_k: 0 skip, 1 data, 2 corrupted skip
    task automatic send_mf(input int len, input int sync_k, input int scram_k, input int skip_k,
                           input int ins_at, input int diag_k, input bit gaps);
        cap_skins = 1'b0;
        for (int k = 0; k < len; k++) begin
            logic        c;
            logic [63:0] d;
            c = 1'b0;
            d = W_DATA | 64'(k);
            if (k == 0) begin
                if (sync_k == 0) begin c = 1'b1; d = W_SYNC; end
            end else if (k == 1) begin
                if (scram_k == 0) begin c = 1'b1; d = W_SCRAM; end
            end else if (k == 2) begin
                if (skip_k == 0) begin c = 1'b1; d = W_SKIP; end
                else if (skip_k == 2) begin c = 1'b1; d = W_BSKIP; end
            end else if (k == len - 1) begin
                if (diag_k == 0) begin c = 1'b1; d = W_DIAG; end
            end else if (k == ins_at) begin
                c = 1'b1; d = W_SKIP;
            end
            drive(c, d);
            if (k == 0) begin
                cap_lock0 = frame_lock; cap_start0 = mf_start;
                cap_mfrm0 = mfrm_err;   cap_serr0  = sync_err;
            end else if (k == 1) begin
                cap_lock1 = frame_lock;
            end else if (k == 2) begin
                cap_pyld2 = pyld_ins; cap_skerr2 = skip_err;
            end
            if (k >= 3 && k < len - 1) cap_skins = cap_skins | skip_ins;
            if (k == len - 1) begin
                cap_derr = diag_err; cap_lock_end = frame_lock;
            end
            if (gaps) idle();
        end
    endtask

    task automatic good_mf(input int len);
        send_mf(len, 0, 0, 0, 0, 0, 1'b0);
    endtask

    task automatic test_reset();
        check("R12", "frame_lock after reset", frame_lock, 1'b0);
        check("R12", "mf_start after reset", mf_start, 1'b0);
        check("R12", "status flags after reset", sync_err | skip_err | diag_err, 1'b0);
        check("R12", "pulses after reset", mfrm_err | skip_ins | pyld_ins, 1'b0);
    endtask

    task automatic test_acquire();
        good_mf(8);
        check("R1", "no lock after first sync", cap_lock0, 1'b0);
        good_mf(8);
        good_mf(8);
        check("R1", "no lock after third sync", cap_lock0, 1'b0);
        good_mf(8);
        check("R1", "lock after fourth sync", cap_lock0, 1'b1);
        check("R4", "start pulse on locking word", cap_start0, 1'b1);
        check("R1", "lock held through metaframe", cap_lock_end, 1'b1);
        good_mf(8);
        check("R4", "start pulse on next boundary", cap_start0, 1'b1);
        check("R5", "no metaframe error on good boundary", cap_mfrm0, 1'b0);
    endtask

    task automatic test_slots();
        send_mf(8, 0, 0, 1, 0, 0, 1'b0);
        check("R6", "payload in skip slot pulses pyld_ins", cap_pyld2, 1'b1);
        check("R6", "data in skip slot leaves skip_err low", cap_skerr2, 1'b0);
        send_mf(8, 0, 0, 2, 0, 0, 1'b0);
        check("R6", "corrupted skip pulses pyld_ins", cap_pyld2, 1'b1);
        check("R6", "corrupted skip sets skip_err", cap_skerr2, 1'b1);
        send_mf(8, 0, 0, 0, 4, 0, 1'b0);
        check("R7", "skip word at position 4 pulses skip_ins", cap_skins, 1'b1);
        check("R6", "good skip clears skip_err", cap_skerr2, 1'b0);
        check("R6", "good skip gives no pyld_ins", cap_pyld2, 1'b0);
        good_mf(8);
        check("R7", "no skip_ins without stray skip", cap_skins, 1'b0);
        send_mf(8, 0, 0, 0, 0, 1, 1'b0);
        check("R8", "wrong diagnostic word sets diag_err", cap_derr, 1'b1);
        good_mf(8);
        check("R8", "good diagnostic word clears diag_err", cap_derr, 1'b0);
    endtask

    task automatic test_gaps();
        send_mf(8, 0, 0, 0, 0, 0, 1'b1);
        check("R11", "lock kept with idle gaps", cap_lock_end, 1'b1);
        check("R11", "no skip error with idle gaps", cap_pyld2, 1'b0);
        good_mf(8);
        check("R11", "boundary still aligned after gaps", cap_start0, 1'b1);
        check("R11", "no metaframe error after gaps", cap_mfrm0, 1'b0);
    endtask

    task automatic test_mfrm();
        send_mf(8, 1, 0, 0, 0, 0, 1'b0);
        check("R5", "missing sync pulses mfrm_err", cap_mfrm0, 1'b1);
        check("R5", "missing sync still pulses mf_start", cap_start0, 1'b1);
        check("R5", "missing sync sets sync_err", cap_serr0, 1'b1);
        check("R5", "lock kept after one missing sync", cap_lock_end, 1'b1);
        good_mf(8);
        check("R5", "good sync clears sync_err", cap_serr0, 1'b0);
        check("R5", "no mfrm_err on good sync", cap_mfrm0, 1'b0);
    endtask

    task automatic test_scrambler();
        send_mf(8, 0, 1, 0, 0, 0, 1'b0);
        send_mf(8, 0, 1, 0, 0, 0, 1'b0);
        check("R3", "lock kept after two mismatches", cap_lock1, 1'b1);
        good_mf(8);
        send_mf(8, 0, 1, 0, 0, 0, 1'b0);
        send_mf(8, 0, 1, 0, 0, 0, 1'b0);
        check("R3", "good match cleared mismatch count", cap_lock1, 1'b1);
        send_mf(8, 0, 1, 0, 0, 0, 1'b0);
        check("R3", "third consecutive mismatch drops lock", cap_lock1, 1'b0);
        check("R3", "lock stays low for rest of metaframe", cap_lock_end, 1'b0);
    endtask

    task automatic test_verify_fail();
        good_mf(8);
        send_mf(8, 1, 0, 0, 0, 0, 1'b0);
        check("R2", "missing sync during confirm keeps unlocked", cap_lock_end, 1'b0);
        good_mf(8);
        good_mf(8);
        good_mf(8);
        check("R2", "three syncs after restart do not lock", cap_lock0, 1'b0);
        good_mf(8);
        check("R2", "fourth sync after restart locks", cap_lock0, 1'b1);
    endtask

    task automatic test_freeze();
        send_mf(8, 1, 0, 2, 0, 1, 1'b0);
        check("R9", "setup sync_err set", sync_err, 1'b1);
        check("R9", "setup skip_err set", skip_err, 1'b1);
        check("R9", "setup diag_err set", diag_err, 1'b1);
        @(negedge clk);
        blk_lock = 1'b0;
        @(posedge clk);
        #1;
        check("R9", "frame_lock low one clock after block lock loss", frame_lock, 1'b0);
        good_mf(8);
        good_mf(8);
        check("R9", "sync_err frozen without block lock", sync_err, 1'b1);
        check("R9", "skip_err frozen without block lock", skip_err, 1'b1);
        check("R9", "diag_err frozen without block lock", diag_err, 1'b1);
        check("R9", "words ignored without block lock", frame_lock | cap_start0, 1'b0);
        @(negedge clk);
        blk_lock = 1'b1;
        good_mf(8);
        good_mf(8);
        good_mf(8);
        check("R9", "no lock yet after three syncs", cap_lock0, 1'b0);
        good_mf(8);
        check("R9", "relock after block lock returns", cap_lock0, 1'b1);
        check("R9", "skip_err updates once relocked", cap_skerr2, 1'b0);
        check("R9", "diag_err updates once relocked", cap_derr, 1'b0);
        good_mf(8);
        check("R9", "sync_err updates once relocked", cap_serr0, 1'b0);
    endtask

    task automatic test_length();
        apply_reset(2);
        test_reset();
        @(negedge clk);
        cfg_len = LEN_W'(8);
        good_mf(4);
        good_mf(4);
        good_mf(4);
        check("R10", "no lock after three short metaframes", cap_lock0, 1'b0);
        good_mf(4);
        check("R10", "length 2 treated as 4 and later change ignored", cap_lock0, 1'b1);
        good_mf(4);
        check("R10", "four-word period holds", cap_start0 & ~cap_mfrm0, 1'b1);
        check("R10", "diagnostic slot at position 3", cap_derr, 1'b0);
    endtask

    initial begin
        apply_reset(8);
        test_reset();
        test_acquire();
        test_slots();
        test_gaps();
        test_mfrm();
        test_scrambler();
        test_verify_fail();
        test_freeze();
        test_length();
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

endmodule